// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block translates a virtual page number into a physical frame number. The translation table lives in memory as a hash table. The walker folds the page number into a bucket index and reads that bucket's head pointer. It then follows a linked chain of elements. At each element it compares the stored page number with the request. When the numbers match it returns the stored frame. When it reaches the end of the chain it reports a miss, which software then handles.

All memory traffic goes through a single word-wide read port with one cycle of latency. Each chain element takes three consecutive words, in this order: the stored page number, the frame word, and the word address of the next element. A pointer value of zero means "no element". A walk stops with an error status if the chain runs longer than a set limit, which guards against corrupted or circular chains. Every result carries the number of elements the walk visited.

Top module: `hpt_walker`

## Requirements
- R1: After a request is accepted, the first memory read goes to word address BKT_BASE + b. Here b is the low BKT_W bits of (upper half of the VPN XOR lower half of the VPN).
- R2: A bucket head word of zero ends the walk at once with status miss (2'b01) and count 0.
- R3: An element at word address p holds the stored VPN at p, the frame at p+1 and the next pointer at p+2. The stored word matches only if it equals the request VPN zero-extended to 32 bits. On a match the result has status hit (2'b00), frame = low FRAME_W bits of word p+1, and count = the 1-based position of the element in the chain.
- R4: A next pointer of zero after a non-matching element gives status miss (2'b01) with frame 0 and count equal to the chain length. This also holds when the chain length equals MAX_CHAIN.
- R5: After MAX_CHAIN non-matching elements, if the next pointer is still non-zero, the walk gives status error (2'b10) with count MAX_CHAIN.
- R6: Every accepted request produces exactly one result, flagged by rsp_valid high for a single cycle. The status is never 2'b11.
- R7: req_ready is high only while the walker is idle. A request presented while req_ready is low is ignored.
- R8: While reset is asserted and right after it is released, req_ready is 1, rsp_valid is 0 and mem_rd_en is 0.
- R9: mem_rd_en is never high on two consecutive cycles, so at most one read is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | AW | Word address of the read |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd_en |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_status | output | 2 | 00 hit, 01 miss, 10 error |
| rsp_frame | output | FRAME_W | Translated frame on a hit, else 0 |
| rsp_count | output | $clog2(MAX_CHAIN+1) | Elements visited during the walk |

## Verification
The assertions check these properties on every cycle:
- each result is a single-cycle pulse with a legal status;
- the walker goes busy right after it accepts a request;
- reads are spaced at least one cycle apart;
- a miss carries a zero frame;
- a hit has a count between 1 and MAX_CHAIN, and an error has a count of exactly MAX_CHAIN.

Only the bench scenarios can show the rest, because it depends on table contents the assertions cannot see:
- which bucket address is read first;
- whether the frame matches the stored element;
- that the count equals the true chain position;
- that a chain of exactly MAX_CHAIN elements still misses rather than failing.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [1:0] {
    WS_HIT  = 2'b00,
    WS_MISS = 2'b01,
    WS_ERR  = 2'b10
  } walk_status_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_WAIT,
    W_HEAD,
    W_VPN,
    W_FRM,
    W_NEXT
  } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W    = 16,
  parameter int BKT_W    = 3,
  parameter int AW       = 10,
  parameter int BKT_BASE = 8
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [AW-1:0]    head_addr
);
  localparam int HALF = VPN_W / 2;

  logic [HALF-1:0] folded;

  assign folded    = vpn[VPN_W-1:HALF] ^ vpn[HALF-1:0];
  assign head_addr = AW'(BKT_BASE) + AW'(folded[BKT_W-1:0]);
endmodule

// File: rtl/hpt_walk_fsm.sv
module hpt_walk_fsm
  import hpt_pkg::*;
#(
  parameter int VPN_W     = 16,
  parameter int FRAME_W   = 20,
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int MAX_CHAIN = 8,
  parameter int CNT_W     = $clog2(MAX_CHAIN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [AW-1:0]      head_addr,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               done,
  output walk_status_e       done_status,
  output logic [FRAME_W-1:0] done_frame,
  output logic [CNT_W-1:0]   done_count
);
  walk_state_e      state, tgt;
  logic [VPN_W-1:0] vpn_q;
  logic [AW-1:0]    cur_q;
  logic [AW-1:0]    addr_q;
  logic             rd_en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ptr_null;
  logic             at_limit;

  assign ptr_null  = (mem_rdata == '0);
  assign at_limit  = (cnt_q == CNT_W'(MAX_CHAIN));
  assign req_ready = (state == W_IDLE);
  assign mem_rd_en = rd_en_q;
  assign mem_addr  = addr_q;

  always_comb begin
    done        = 1'b0;
    done_status = WS_MISS;
    done_frame  = '0;
    done_count  = cnt_q;
    case (state)
      W_HEAD: done = ptr_null;
      W_FRM: begin
        done        = 1'b1;
        done_status = WS_HIT;
        done_frame  = mem_rdata[FRAME_W-1:0];
      end
      W_NEXT: begin
        if (ptr_null) begin
          done = 1'b1;
        end else if (at_limit) begin
          done        = 1'b1;
          done_status = WS_ERR;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= W_IDLE;
      tgt     <= W_IDLE;
      vpn_q   <= '0;
      cur_q   <= '0;
      addr_q  <= '0;
      rd_en_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      rd_en_q <= 1'b0;
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            vpn_q   <= req_vpn;
            cnt_q   <= '0;
            addr_q  <= head_addr;
            rd_en_q <= 1'b1;
            tgt     <= W_HEAD;
            state   <= W_WAIT;
          end
        end
        W_WAIT: state <= tgt;
        W_HEAD: begin
          if (ptr_null) begin
            state <= W_IDLE;
          end else begin
            cur_q   <= mem_rdata[AW-1:0];
            addr_q  <= mem_rdata[AW-1:0];
            rd_en_q <= 1'b1;
            tgt     <= W_VPN;
            state   <= W_WAIT;
          end
        end
        W_VPN: begin
          cnt_q   <= cnt_q + CNT_W'(1);
          rd_en_q <= 1'b1;
          state   <= W_WAIT;
          if (mem_rdata == DW'(vpn_q)) begin
            addr_q <= cur_q + AW'(1);
            tgt    <= W_FRM;
          end else begin
            addr_q <= cur_q + AW'(2);
            tgt    <= W_NEXT;
          end
        end
        W_FRM: state <= W_IDLE;
        W_NEXT: begin
          if (ptr_null || at_limit) begin
            state <= W_IDLE;
          end else begin
            cur_q   <= mem_rdata[AW-1:0];
            addr_q  <= mem_rdata[AW-1:0];
            rd_en_q <= 1'b1;
            tgt     <= W_VPN;
            state   <= W_WAIT;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_rsp_reg.sv
module hpt_rsp_reg
  import hpt_pkg::*;
#(
  parameter int FRAME_W = 20,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  walk_status_e       done_status,
  input  logic [FRAME_W-1:0] done_frame,
  input  logic [CNT_W-1:0]   done_count,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [CNT_W-1:0]   rsp_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 2'b00;
      rsp_frame  <= '0;
      rsp_count  <= '0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_status <= done_status;
        rsp_frame  <= done_frame;
        rsp_count  <= done_count;
      end
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int VPN_W     = 16,
  parameter int BKT_W     = 3,
  parameter int FRAME_W   = 20,
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int MAX_CHAIN = 8,
  parameter int BKT_BASE  = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req_valid,
  input  logic [VPN_W-1:0]                   req_vpn,
  output logic                               req_ready,
  output logic                               mem_rd_en,
  output logic [AW-1:0]                      mem_addr,
  input  logic [DW-1:0]                      mem_rdata,
  output logic                               rsp_valid,
  output logic [1:0]                         rsp_status,
  output logic [FRAME_W-1:0]                 rsp_frame,
  output logic [$clog2(MAX_CHAIN+1)-1:0]     rsp_count
);
  localparam int CNT_W = $clog2(MAX_CHAIN + 1);

  logic [AW-1:0]      head_addr;
  logic               done;
  walk_status_e       done_status;
  logic [FRAME_W-1:0] done_frame;
  logic [CNT_W-1:0]   done_count;

  hpt_hash #(
    .VPN_W(VPN_W), .BKT_W(BKT_W), .AW(AW), .BKT_BASE(BKT_BASE)
  ) u_hash (
    .vpn       (req_vpn),
    .head_addr (head_addr)
  );

  hpt_walk_fsm #(
    .VPN_W(VPN_W), .FRAME_W(FRAME_W), .AW(AW), .DW(DW),
    .MAX_CHAIN(MAX_CHAIN), .CNT_W(CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_vpn     (req_vpn),
    .head_addr   (head_addr),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .done_status (done_status),
    .done_frame  (done_frame),
    .done_count  (done_count)
  );

  hpt_rsp_reg #(
    .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_rsp (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .done_status (done_status),
    .done_frame  (done_frame),
    .done_count  (done_count),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_frame   (rsp_frame),
    .rsp_count   (rsp_count)
  );
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int FRAME_W   = 20,
  parameter int MAX_CHAIN = 8,
  parameter int CNT_W     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               mem_rd_en,
  input logic               rsp_valid,
  input logic [1:0]         rsp_status,
  input logic [FRAME_W-1:0] rsp_frame,
  input logic [CNT_W-1:0]   rsp_count
);
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R6
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'b11)); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R7
  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R7
  AST_READ_SPACING: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R9
  AST_MISS_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b01) |-> (rsp_frame == '0)); // R4
  AST_HIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b00) |->
      (rsp_count != '0 && rsp_count <= CNT_W'(MAX_CHAIN))); // R3
  AST_ERR_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b10) |-> (rsp_count == CNT_W'(MAX_CHAIN))); // R5
endmodule

bind hpt_walker hpt_walker_chk #(
  .FRAME_W(FRAME_W), .MAX_CHAIN(MAX_CHAIN), .CNT_W($clog2(MAX_CHAIN + 1))
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_rd_en  (mem_rd_en),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_frame  (rsp_frame),
  .rsp_count  (rsp_count)
);

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  localparam int VPN_W = 16, BKT_W = 3, FRAME_W = 20, AW = 10, DW = 32;
  localparam int MAX_CHAIN = 8, BKT_BASE = 8;
  localparam int CNT_W = $clog2(MAX_CHAIN + 1);
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic req_ready, mem_rd_en, rsp_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [1:0] rsp_status;
  logic [FRAME_W-1:0] rsp_frame;
  logic [CNT_W-1:0] rsp_count;

  logic [DW-1:0] mem [DEPTH];

  int checks = 0;
  int failures = 0;
  int accepted = 0;
  int responses = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  always @(negedge clk) if (!rst && rsp_valid) responses++;

  hpt_walker #(
    .VPN_W(VPN_W), .BKT_W(BKT_W), .FRAME_W(FRAME_W), .AW(AW), .DW(DW),
    .MAX_CHAIN(MAX_CHAIN), .BKT_BASE(BKT_BASE)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_frame(rsp_frame), .rsp_count(rsp_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  function automatic int bucket_addr(input logic [VPN_W-1:0] v);
    logic [7:0] f;
    f = v[15:8] ^ v[7:0];
    return BKT_BASE + int'(f[BKT_W-1:0]);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic ref_walk(input logic [VPN_W-1:0] v, output int st, output int fr, output int cnt);
    int p;
    st = 1; fr = 0; cnt = 0;
    p = int'(mem[bucket_addr(v)][AW-1:0]);
    if (mem[bucket_addr(v)] == 0) return;
    for (int k = 0; k < 64; k++) begin
      cnt++;
      if (mem[p] == DW'(v)) begin
        st = 0;
        fr = int'(mem[p + 1][FRAME_W-1:0]);
        return;
      end
      if (mem[p + 2] == 0) return;
      if (cnt == MAX_CHAIN) begin
        st = 2;
        return;
      end
      p = int'(mem[p + 2][AW-1:0]);
    end
  endtask

  task automatic query(input logic [VPN_W-1:0] v, output int st, output int fr,
                       output int cnt, output int first_addr);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vpn = v;
    @(negedge clk);
    req_valid = 1'b0;
    accepted++;
    first_addr = mem_rd_en ? int'(mem_addr) : -1;
    guard = 0;
    while (!rsp_valid && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    st = int'(rsp_status);
    fr = int'(rsp_frame);
    cnt = int'(rsp_count);
  endtask

  task automatic query_and_check(input logic [VPN_W-1:0] v);
    int st, fr, cnt, fa, est, efr, ecnt;
    ref_walk(v, est, efr, ecnt);
    query(v, st, fr, cnt, fa);
    check(fa == bucket_addr(v), "R1 first read address", fa, bucket_addr(v));
    if (est == 0)
      check(st == 0 && fr == efr && cnt == ecnt, "R3 hit status/frame/count",
            (st << 28) | (cnt << 20) | fr, (est << 28) | (ecnt << 20) | efr);
    else if (est == 2)
      check(st == 2 && cnt == ecnt, "R5 limit error", (st << 8) | cnt, (est << 8) | ecnt);
    else if (ecnt == 0)
      check(st == 1 && cnt == 0, "R2 empty bucket miss", (st << 8) | cnt, (est << 8) | ecnt);
    else
      check(st == 1 && fr == 0 && cnt == ecnt, "R4 end-of-chain miss",
            (st << 28) | (cnt << 20) | fr, (est << 28) | (ecnt << 20));
  endtask

  int heads [8];
  int nxt_free;

  task automatic insert_head(input logic [VPN_W-1:0] v, input int frame);
    int b;
    b = bucket_addr(v);
    mem[nxt_free] = DW'(v);
    mem[nxt_free + 1] = DW'(frame);
    mem[nxt_free + 2] = mem[b];
    mem[b] = DW'(nxt_free);
    nxt_free += 3;
  endtask

  initial begin
    int st, fr, cnt, fa, resp_before;
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset values while reset is held
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R8 reset outputs",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R8 after reset",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);

    // Sweep: populated table, inserted VPNs and a range of absent VPNs
    nxt_free = 64;
    for (int i = 0; i < 30; i++)
      insert_head(VPN_W'(i * 16'h02b3 + 16'h0011), 20'hA0000 + i * 7);
    for (int i = 0; i < 30; i++) query_and_check(VPN_W'(i * 16'h02b3 + 16'h0011));
    for (int v = 0; v < 200; v++) query_and_check(VPN_W'(v * 16'h0137));

    // R2: empty bucket
    clear_mem();
    query(16'h0005, st, fr, cnt, fa);
    check(st == 1 && cnt == 0, "R2 empty bucket", (st << 8) | cnt, 16'h0100);

    // R5: circular chain
    mem[BKT_BASE + 1] = 200;
    mem[200] = 32'h0200; mem[201] = 32'h11; mem[202] = 203;
    mem[203] = 32'h0300; mem[204] = 32'h22; mem[205] = 200;
    query(16'h0100, st, fr, cnt, fa);
    check(st == 2 && cnt == MAX_CHAIN, "R5 circular chain", (st << 8) | cnt, (2 << 8) | MAX_CHAIN);

    // Chain of exactly MAX_CHAIN elements in bucket 0, built head-first
    clear_mem();
    mem[BKT_BASE] = 300;
    for (int k = 1; k <= MAX_CHAIN; k++) begin
      mem[300 + 3 * (k - 1)] = DW'(k * 16'h0101);
      mem[300 + 3 * (k - 1) + 1] = DW'(20'h50000 + k);
      mem[300 + 3 * (k - 1) + 2] = (k == MAX_CHAIN) ? 0 : DW'(300 + 3 * k);
    end
    query(VPN_W'(MAX_CHAIN * 16'h0101), st, fr, cnt, fa);
    check(st == 0 && cnt == MAX_CHAIN && fr == 20'h50000 + MAX_CHAIN, "R3 hit at last element",
          (st << 28) | (cnt << 20) | fr, (MAX_CHAIN << 20) | (20'h50000 + MAX_CHAIN));
    query(16'h0101, st, fr, cnt, fa);
    check(st == 0 && cnt == 1 && fr == 20'h50001, "R3 hit at first element",
          (st << 28) | (cnt << 20) | fr, (1 << 20) | 20'h50001);
    query(16'h0F0F, st, fr, cnt, fa);
    check(st == 1 && cnt == MAX_CHAIN && fr == 0, "R4 miss at full length",
          (st << 8) | cnt, (1 << 8) | MAX_CHAIN);
    // one more element makes the absent lookup exceed the limit
    mem[300 + 3 * (MAX_CHAIN - 1) + 2] = 500;
    mem[500] = 32'h0E0E; mem[501] = 32'h1; mem[502] = 0;
    query(16'h0F0F, st, fr, cnt, fa);
    check(st == 2 && cnt == MAX_CHAIN, "R5 chain beyond limit", (st << 8) | cnt, (2 << 8) | MAX_CHAIN);

    // R3: stored word with upper bits set must not match
    clear_mem();
    mem[bucket_addr(16'h0123)] = 600;
    mem[600] = 32'h0001_0123; mem[601] = 32'h7; mem[602] = 603;
    mem[603] = 32'h0000_0123; mem[604] = 32'h9; mem[605] = 0;
    query(16'h0123, st, fr, cnt, fa);
    check(st == 0 && cnt == 2 && fr == 9, "R3 full-word compare",
          (st << 28) | (cnt << 20) | fr, (2 << 20) | 9);

    // R7: request held while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    resp_before = responses;
    req_valid = 1'b1; req_vpn = 16'h0123;
    @(negedge clk);
    accepted++;
    req_vpn = 16'h0005;
    check(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_status == 2'b00 && rsp_frame == 9, "R7 busy request ignored",
          int'(rsp_frame), 9);
    repeat (30) @(negedge clk);
    check(responses == resp_before + 1, "R7 no extra result", responses - resp_before, 1);

    // R6: one result per accepted request
    check(responses == accepted, "R6 result count", responses, accepted);
    finish_run();
  end
endmodule